// File: doc/BRIEF.md
# Walking-One Serial Output Test Driver

This block exercises an external serial-in, parallel-out shift register that has latched outputs. It drives the register over four wires: an active-low clear, a serial data bit, a shift clock and a store strobe. One start pulse sets off a fixed test sequence of sixteen words. Each word carries a single set bit, and that bit sits one place higher in each word than in the word before it. A board-level check can then watch every parallel output of the register go high in turn. A one-cycle done pulse reports that the sequence has finished.

The sequence is built from phases. A phase lasts `DIV` system clock cycles, where `DIV` is a parameter of at least 1, so the wire timing can be slowed to suit the external part. All four wires come straight from flip-flops, so they cannot glitch.

Top module: `sipo_walk_driver`

## Requirements
- R1: After a synchronous reset, and whenever the block is idle, `clr_n` is 1 and `ser_data`, `shift_clk`, `store` and `done` are all 0.
- R2: A `start` sampled high while idle begins the sequence. The first phase is visible in the cycle after that clock edge, and every phase lasts exactly `DIV` cycles.
- R3: Each word opens with one phase of `clr_n` = 0, followed by one phase of `clr_n` = 1.
- R4: Each word shifts all 16 bits, with bit index 0 first. Each bit takes three phases in this order: the data is set with `shift_clk` low, then `shift_clk` goes high, then `shift_clk` goes low. `ser_data` holds the bit's value for all three phases and is 0 in every other phase.
- R5: After the 16th bit of a word, `store` is 1 for one phase and then 0 for one phase.
- R6: Word w (counting from w = 0) has only bit w set. A receiver that clears on `clr_n` = 0, shifts toward higher stage indexes on each rising edge of `shift_clk`, and copies its stages on each rising edge of `store` holds exactly stage 15−w set after word w.
- R7: The sequence has exactly 16 words. `done` is high for exactly one cycle, in the cycle right after the last phase ends, and the wires are back at their idle values in that same cycle.
- R8: A `start` pulse that arrives while the sequence is running has no effect on any output.
- R9: A reset in the middle of a sequence returns the block to idle in the next cycle. The next start then begins again from the word with only bit 0 set.
- R10: `shift_clk` and `store` are never high together, and `clr_n` is 1 whenever either of them is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launches the test sequence when the block is idle |
| clr_n | output | 1 | Clear for the external register, active low |
| ser_data | output | 1 | Serial data bit |
| shift_clk | output | 1 | Shift clock for the external register |
| store | output | 1 | Output latch strobe |
| done | output | 1 | One-cycle pulse at the end of the sequence |

## Verification
Every output is registered, so the first phase shows up in the cycle after the edge that samples `start`. From then on, the output value at cycle t of a run depends only on phase t/DIV. The bench computes that phase value arithmetically and compares all four wires in every cycle of a run, sampling on the falling clock edge. It expects `done` exactly 52·16·DIV cycles after the start edge, and expects it low again one cycle later. A behavioural receiver fed from the sampled wires checks the latched pattern at each strobe. An idle check one cycle after reset covers the mid-sequence abort.

// File: rtl/walk_pkg.sv
package walk_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CLR_LO,
        PH_CLR_HI,
        PH_DAT,
        PH_CLK_HI,
        PH_CLK_LO,
        PH_STB_HI,
        PH_STB_LO
    } phase_e;

    typedef struct packed {
        logic clr_n;
        logic data;
        logic shclk;
        logic store;
    } pins_t;

    localparam pins_t PINS_IDLE = 4'b1000;

    // Wire levels that belong to a phase; bitv is the serial bit in flight.
    function automatic pins_t pins_for(input phase_e ph, input logic bitv);
        pins_t p;
        p = PINS_IDLE;
        case (ph)
            PH_CLR_LO: p.clr_n = 1'b0;
            PH_DAT:    p.data  = bitv;
            PH_CLK_HI: begin
                p.data  = bitv;
                p.shclk = 1'b1;
            end
            PH_CLK_LO: p.data  = bitv;
            PH_STB_HI: p.store = 1'b1;
            default:   p = PINS_IDLE;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/walk_phase_timer.sv
module walk_phase_timer #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == LAST);

    // R2: the phase counter never passes its last value
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
        int'(cnt) < DIV);

    generate
        if (DIV > 1) begin : g_gap
            // R2: a phase of several cycles never ends on two cycles in a row
            p_tick_gap_r2: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/walk_word_reg.sv
module walk_word_reg #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              adv,
    output logic [WORD_W-1:0] word
);
    localparam logic [WORD_W-1:0] FIRST = WORD_W'(1);

    always_ff @(posedge clk) begin
        if (rst || load) begin
            word <= FIRST;
        end else if (adv) begin
            word <= {word[WORD_W-2:0], 1'b0};
        end
    end

    // R6: the test word never carries more than one set bit
    p_single_bit_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(word));

    // R9: a fresh launch always begins from bit 0
    p_load_first_r9: assert property (@(posedge clk) disable iff (rst)
        load |=> word[0]);

endmodule

// File: rtl/walk_seq_fsm.sv
module walk_seq_fsm
    import walk_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              tick,
    input  logic [WORD_W-1:0] word,
    output pins_t             pins,
    output logic              done,
    output logic              busy,
    output logic              load_word,
    output logic              adv_word
);
    localparam int BIT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [BIT_W-1:0] LAST_IDX = BIT_W'(WORD_W - 1);

    phase_e           state, nstate;
    logic [BIT_W-1:0] bit_q, nbit;
    logic [BIT_W-1:0] wrd_q, nwrd;
    logic             fin;

    always_comb begin
        nstate    = state;
        nbit      = bit_q;
        nwrd      = wrd_q;
        load_word = 1'b0;
        adv_word  = 1'b0;
        fin       = 1'b0;
        if (state == PH_IDLE) begin
            if (start) begin
                nstate    = PH_CLR_LO;
                nbit      = '0;
                nwrd      = '0;
                load_word = 1'b1;
            end
        end else if (tick) begin
            case (state)
                PH_CLR_LO: nstate = PH_CLR_HI;
                PH_CLR_HI: begin
                    nstate = PH_DAT;
                    nbit   = '0;
                end
                PH_DAT:    nstate = PH_CLK_HI;
                PH_CLK_HI: nstate = PH_CLK_LO;
                PH_CLK_LO: begin
                    if (bit_q == LAST_IDX) begin
                        nstate = PH_STB_HI;
                    end else begin
                        nstate = PH_DAT;
                        nbit   = bit_q + 1'b1;
                    end
                end
                PH_STB_HI: nstate = PH_STB_LO;
                PH_STB_LO: begin
                    adv_word = 1'b1;
                    if (wrd_q == LAST_IDX) begin
                        nstate = PH_IDLE;
                        fin    = 1'b1;
                    end else begin
                        nstate = PH_CLR_LO;
                        nwrd   = wrd_q + 1'b1;
                    end
                end
                default:   nstate = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PH_IDLE;
            bit_q <= '0;
            wrd_q <= '0;
            pins  <= PINS_IDLE;
            done  <= 1'b0;
        end else begin
            state <= nstate;
            bit_q <= nbit;
            wrd_q <= nwrd;
            pins  <= pins_for(nstate, word[nbit]);
            done  <= fin;
        end
    end

    assign busy = (state != PH_IDLE);

    // R8: a start seen mid-sequence between phase ends leaves the phase alone
    p_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !tick) |=> $stable(state));

    // R4: the data bit does not move while the shift clock is high
    p_data_hold_r4: assert property (@(posedge clk) disable iff (rst)
        pins.shclk |-> (pins.data == $past(pins.data)));

    // R7: completion is reported only once the sequencer is back at rest
    p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> (state == PH_IDLE));

    // R3: a clear phase is always followed by the released-clear phase
    p_clr_order_r3: assert property (@(posedge clk) disable iff (rst)
        (state == PH_CLR_LO && tick) |=> (state == PH_CLR_HI));

endmodule

// File: rtl/sipo_walk_driver.sv
module sipo_walk_driver
    import walk_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int DIV    = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic clr_n,
    output logic ser_data,
    output logic shift_clk,
    output logic store,
    output logic done
);
    logic              tick;
    logic              busy;
    logic              load_word;
    logic              adv_word;
    logic [WORD_W-1:0] word;
    pins_t             pins;

    walk_phase_timer #(.DIV(DIV)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .tick (tick)
    );

    walk_word_reg #(.WORD_W(WORD_W)) u_word (
        .clk  (clk),
        .rst  (rst),
        .load (load_word),
        .adv  (adv_word),
        .word (word)
    );

    walk_seq_fsm #(.WORD_W(WORD_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .tick      (tick),
        .word      (word),
        .pins      (pins),
        .done      (done),
        .busy      (busy),
        .load_word (load_word),
        .adv_word  (adv_word)
    );

    assign clr_n     = pins.clr_n;
    assign ser_data  = pins.data;
    assign shift_clk = pins.shclk;
    assign store     = pins.store;

    // R10: shifting and latching never overlap
    p_clk_store_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(shift_clk && store));

    // R10: clear is released whenever a clock or strobe edge is offered
    p_clr_released_r10: assert property (@(posedge clk) disable iff (rst)
        (shift_clk || store) |-> clr_n);

    // R7: the completion flag is a single-cycle pulse
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R1: completion leaves the wires at their rest levels
    p_done_rest_r1: assert property (@(posedge clk) disable iff (rst)
        done |-> (clr_n && !ser_data && !shift_clk && !store));

endmodule

// File: tb/test_sipo_walk_driver.sv
module test_sipo_walk_driver;
    localparam int W    = 16;
    localparam int DIV  = 3;
    localparam int PPW  = 3 * W + 4;
    localparam int N    = PPW * W * DIV;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic clr_n, ser_data, shift_clk, store, done;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    sipo_walk_driver #(.WORD_W(W), .DIV(DIV)) i_sipo_walk_driver (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .clr_n     (clr_n),
        .ser_data  (ser_data),
        .shift_clk (shift_clk),
        .store     (store),
        .done      (done)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // {clr_n, data, shift_clk, store} expected at cycle t of a run
    function automatic logic [3:0] exp_pins(input int t);
        int p, q, w, b, s;
        logic [3:0] e;
        p = t / DIV;
        q = p % PPW;
        w = p / PPW;
        e = 4'b1000;
        if (q == 0) begin
            e = 4'b0000;
        end else if (q >= 2 && q < 2 + 3 * W) begin
            b = (q - 2) / 3;
            s = (q - 2) % 3;
            e[2] = (b == w);
            e[1] = (s == 1);
        end else if (q == 2 + 3 * W) begin
            e[0] = 1'b1;
        end
        return e;
    endfunction

    function automatic string req_of(input int t);
        int q;
        q = (t / DIV) % PPW;
        if (t < DIV)           return "R2";
        if (q < 2)             return "R3";
        if (q < 2 + 3 * W)     return "R4";
        return "R5";
    endfunction

    task automatic run_trace(input bit poke);
        logic [W-1:0] rx_sr;
        logic [3:0]   act;
        logic         prev_sc, prev_st;
        int           n_stb, poke_t;
        string        tag;
        rx_sr   = '0;
        prev_sc = 1'b0;
        prev_st = 1'b0;
        n_stb   = 0;
        poke_t  = 40 * DIV + 1;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int t = 0; t <= N + 1; t++) begin
            act = {clr_n, ser_data, shift_clk, store};
            if (t < N) begin
                tag = (poke && t > poke_t) ? "R8" : req_of(t);
                chk(act == exp_pins(t) && !done, tag, {act, done}, {exp_pins(t), 1'b0});
                if (!clr_n) begin
                    rx_sr = '0;
                end else if (shift_clk && !prev_sc) begin
                    rx_sr = {rx_sr[W-2:0], ser_data};
                end
                if (store && !prev_st) begin
                    chk(int'(rx_sr) == (1 << (W - 1 - n_stb)), "R6",
                        int'(rx_sr), 1 << (W - 1 - n_stb));
                    n_stb++;
                end
                prev_sc = shift_clk;
                prev_st = store;
            end else if (t == N) begin
                chk(done && act == 4'b1000, "R7", {act, done}, 5'b10001);
                chk(n_stb == W, "R7", n_stb, W);
            end else begin
                chk(!done && act == 4'b1000, "R7", {act, done}, 5'b10000);
            end
            if (poke && (t == poke_t || t == poke_t + 7 * DIV)) start = 1'b1;
            else start = 1'b0;
            @(negedge clk);
        end
        start = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL R7: watchdog expired, actual running expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk({clr_n, ser_data, shift_clk, store, done} == 5'b10000, "R1",
            {clr_n, ser_data, shift_clk, store, done}, 5'b10000);
        rst = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk({clr_n, ser_data, shift_clk, store, done} == 5'b10000, "R1",
                {clr_n, ser_data, shift_clk, store, done}, 5'b10000);
        end

        run_trace(1'b0);
        run_trace(1'b1);

        // R9: abort in mid-run, then a fresh run must start from bit 0
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (150) @(negedge clk);
        rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        chk({clr_n, ser_data, shift_clk, store, done} == 5'b10000, "R9",
            {clr_n, ser_data, shift_clk, store, done}, 5'b10000);
        repeat (5) @(negedge clk);
        chk({clr_n, ser_data, shift_clk, store, done} == 5'b10000, "R9",
            {clr_n, ser_data, shift_clk, store, done}, 5'b10000);
        run_trace(1'b0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule